// File: doc/BRIEF.md
# Software-Managed Set-Associative TLB

This block is the main translation buffer of a memory management unit whose refill is left to software. Entries live in an array of sets by ways. Software stages a virtual-side descriptor (page number, address-space tag, valid and global bits) and a physical-side descriptor (frame and permissions) in two holding registers. It stages an entry number in a slot register, then issues a one-cycle command. The commands search the array for the staged virtual descriptor, allocate a slot, store the staged pair, fetch an entry back into the holding registers, or only flush the small first-level translation caches. Those caches are represented here only by a one-cycle flush pulse.

The slot number is linear: `set * WAYS + way`, so the ways of one set sit at consecutive numbers. A search reports a plain miss and a duplicate match as two separate flags. Duplicate entries are therefore caught when looked up, not when stored. An entry is erased by storing an all-zero pair at its slot.

Top module: `sw_tlb`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid, and `slot_out`, `miss_flag`, `dup_flag`, `utlb_flush`, `vtag_out` and `pfn_out` are all zero.
- R2: A write strobe loads its holding register (`vtag_out`, `pfn_out`, `slot_out`) at the next edge. A command issued in the same cycle sees the old values. Command codes on `cmd_op` are: 0 none, 1 search, 2 allocate, 3 store, 4 quiet store, 5 fetch, 6 flush only. The virtual descriptor layout is bits [31:13] page number, bit 9 valid, bit 8 global, bits [7:0] address-space tag.
- R3: Search compares page number and tag of the virtual register against the valid ways of its set. On a single match it loads `slot_out` with `set*WAYS+way` and clears both flags.
- R4: A search with no match sets `miss_flag`, clears `dup_flag` and leaves `slot_out` unchanged.
- R5: A search matching two or more ways sets `dup_flag` and clears `miss_flag`. It loads `slot_out` with the lowest matching way.
- R6: An entry stored with the global bit (bit 8) matches any address-space tag.
- R7: Allocate selects the set from page-number bits [19:13] (the low page-number bits, 8 KB pages, 128 sets). It loads `slot_out` with the lowest invalid way of that set and clears both flags.
- R8: When every way of the set is valid, allocate takes a per-set round-robin way. The way starts at 0 after reset and advances by one each time it is used.
- R9: Store writes both holding registers at the entry named by `slot_out` and raises `utlb_flush` for exactly the next cycle. Quiet store writes the same entry without the pulse. Neither changes the flags.
- R10: Fetch loads `vtag_out` and `pfn_out` from the entry named by `slot_out`, with the valid bit as currently held, and leaves `slot_out` unchanged.
- R11: The flush-only command raises `utlb_flush` for one cycle and changes no register or entry.
- R12: Storing an all-zero pair erases the entry. It then matches no search and fetches back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vtag_we | input | 1 | Load virtual descriptor register |
| vtag_wdata | input | 32 | Virtual descriptor write data |
| pfn_we | input | 1 | Load physical descriptor register |
| pfn_wdata | input | 32 | Physical descriptor write data |
| slot_we | input | 1 | Load slot register |
| slot_wdata | input | IDX_W (9) | Slot write data |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code |
| vtag_out | output | 32 | Virtual descriptor register |
| pfn_out | output | 32 | Physical descriptor register |
| slot_out | output | IDX_W (9) | Slot register |
| miss_flag | output | 1 | Last search found no match |
| dup_flag | output | 1 | Last search found several matches |
| utlb_flush | output | 1 | One-cycle first-level cache flush pulse |

## Verification
Searches are tried with four kinds of key. The first matches one way exactly. The second differs only in address-space tag, which separates a tag compare from a page compare. The third hits a global entry under a foreign tag. The fourth matches two ways, which separates a duplicate from a hit. Allocation is tried in a set with free ways, a full set (twice, to expose the round-robin step), a set with a hole after an erase (lowest free way must beat the pointer), and a different set, which shows that set selection follows the page-number bits. A mid-run reset followed by a search shows that valid bits and not stored contents decide a match.

// File: rtl/sw_tlb_pkg.sv
// Shared encodings for the software-managed TLB.
// Assumes a 32-bit virtual descriptor with page number above PAGE_SHIFT.
package sw_tlb_pkg;
    localparam int PAGE_SHIFT = 13;
    localparam int VT_VALID   = 9;
    localparam int VT_GLOBAL  = 8;
    localparam int ASID_W     = 8;
    localparam int DESC_W     = 32;

    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_SEARCH      = 3'd1,
        OP_ALLOC       = 3'd2,
        OP_STORE       = 3'd3,
        OP_STORE_QUIET = 3'd4,
        OP_FETCH       = 3'd5,
        OP_UFLUSH      = 3'd6
    } cmd_e;
endpackage

// File: rtl/sw_tlb_way_cmp.sv
// Compares one search key against all ways of a set.
// Reports the hit vector, the lowest hitting way and whether several hit.
// Assumes WAYS is a power of two, at least 2.
module sw_tlb_way_cmp #(
    parameter int WAYS  = 4,
    parameter int VPN_W = 19,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             ent_valid,
    input  logic [WAYS-1:0]             ent_glob,
    input  logic [WAYS-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [WAYS-1:0][TAG_W-1:0]  ent_tag,
    input  logic [VPN_W-1:0]            key_vpn,
    input  logic [TAG_W-1:0]            key_tag,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        hit_any,
    output logic                        hit_multi
);
    localparam int CNT_W = $clog2(WAYS + 1);

    logic [WAYS-1:0] hit_vec;
    logic [CNT_W-1:0] hit_cnt;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        // Per-way match: valid, same page, and same tag unless global
        assign hit_vec[w] = ent_valid[w] && (ent_vpn[w] == key_vpn) &&
                            (ent_glob[w] || (ent_tag[w] == key_tag));
    end

    // Encode the lowest hitting way and count the hits
    always_comb begin
        hit_way = '0;
        hit_cnt = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            hit_cnt = hit_cnt + CNT_W'(hit_vec[w]);
        end
    end

    assign hit_any   = |hit_vec;
    assign hit_multi = hit_cnt > CNT_W'(1);
endmodule

// File: rtl/sw_tlb_victim_sel.sv
// Picks the way to allocate in one set: lowest invalid way,
// else the set's round-robin pointer. Assumes WAYS is a power of two.
module sw_tlb_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] pick_way,
    output logic             set_full
);
    // Priority scan for a free way, falling back to the pointer
    always_comb begin
        pick_way = rr_ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) pick_way = WAY_W'(w);
        end
    end

    assign set_full = &valid_vec;
endmodule

// File: rtl/sw_tlb.sv
// Software-managed set-associative TLB with holding registers and commands.
// Commands complete in one cycle; results are visible on the next cycle.
// Assumes SETS and WAYS are powers of two and WAYS >= 2.
module sw_tlb
    import sw_tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS) + $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vtag_we,
    input  logic [31:0]       vtag_wdata,
    input  logic              pfn_we,
    input  logic [31:0]       pfn_wdata,
    input  logic              slot_we,
    input  logic [IDX_W-1:0]  slot_wdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    output logic [31:0]       vtag_out,
    output logic [31:0]       pfn_out,
    output logic [IDX_W-1:0]  slot_out,
    output logic              miss_flag,
    output logic              dup_flag,
    output logic              utlb_flush
);
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int ENTRIES = SETS * WAYS;
    localparam int VPN_W   = DESC_W - PAGE_SHIFT;

    logic [DESC_W-1:0] vtag_q, pfn_q;
    logic [IDX_W-1:0]  slot_q;
    logic              miss_q, dup_q, flush_q;

    logic [DESC_W-1:0] vt_mem [ENTRIES];
    logic [DESC_W-1:0] pf_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [WAY_W-1:0]  rr_q [SETS];

    cmd_e op;
    logic do_cmd, do_store;
    logic [SET_W-1:0] key_set;

    logic [WAYS-1:0]            set_valid, set_glob;
    logic [WAYS-1:0][VPN_W-1:0] set_vpn;
    logic [WAYS-1:0][ASID_W-1:0] set_tag;
    logic [WAY_W-1:0] hit_way, pick_way;
    logic hit_any, hit_multi, set_full;
    logic [DESC_W-1:0] rd_vt;

    assign op       = cmd_e'(cmd_op);
    assign do_cmd   = cmd_valid;
    assign do_store = do_cmd && (op == OP_STORE || op == OP_STORE_QUIET);
    assign key_set  = vtag_q[PAGE_SHIFT +: SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_set
        localparam logic [WAY_W-1:0] WV = WAY_W'(w);
        // Gather the ways of the set addressed by the virtual register
        assign set_valid[w] = valid_q[{key_set, WV}];
        assign set_glob[w]  = vt_mem[{key_set, WV}][VT_GLOBAL];
        assign set_vpn[w]   = vt_mem[{key_set, WV}][DESC_W-1:PAGE_SHIFT];
        assign set_tag[w]   = vt_mem[{key_set, WV}][ASID_W-1:0];
    end

    sw_tlb_way_cmp #(.WAYS(WAYS), .VPN_W(VPN_W), .TAG_W(ASID_W)) cmp_i (
        .ent_valid (set_valid),
        .ent_glob  (set_glob),
        .ent_vpn   (set_vpn),
        .ent_tag   (set_tag),
        .key_vpn   (vtag_q[DESC_W-1:PAGE_SHIFT]),
        .key_tag   (vtag_q[ASID_W-1:0]),
        .hit_way   (hit_way),
        .hit_any   (hit_any),
        .hit_multi (hit_multi)
    );

    sw_tlb_victim_sel #(.WAYS(WAYS)) vsel_i (
        .valid_vec (set_valid),
        .rr_ptr    (rr_q[key_set]),
        .pick_way  (pick_way),
        .set_full  (set_full)
    );

    // Read path of the slot register, valid bit taken from the flop array
    always_comb begin
        rd_vt = vt_mem[slot_q];
        rd_vt[VT_VALID] = valid_q[slot_q];
    end

    // Holding registers, slot register, flags and flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtag_q  <= '0;
            pfn_q   <= '0;
            slot_q  <= '0;
            miss_q  <= 1'b0;
            dup_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (vtag_we) vtag_q <= vtag_wdata;
            if (pfn_we)  pfn_q  <= pfn_wdata;
            if (slot_we) slot_q <= slot_wdata;
            if (do_cmd) begin
                case (op)
                    OP_SEARCH: begin
                        miss_q <= !hit_any;
                        dup_q  <= hit_multi;
                        if (hit_any) slot_q <= {key_set, hit_way};
                    end
                    OP_ALLOC: begin
                        miss_q <= 1'b0;
                        dup_q  <= 1'b0;
                        slot_q <= {key_set, pick_way};
                    end
                    OP_STORE:  flush_q <= 1'b1;
                    OP_UFLUSH: flush_q <= 1'b1;
                    OP_FETCH: begin
                        vtag_q <= rd_vt;
                        pfn_q  <= pf_mem[slot_q];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Valid bits and per-set round-robin pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else begin
            if (do_store) valid_q[slot_q] <= vtag_q[VT_VALID];
            if (do_cmd && op == OP_ALLOC && set_full)
                rr_q[key_set] <= rr_q[key_set] + WAY_W'(1);
        end
    end

    // Entry contents, written by store commands only
    always_ff @(posedge clk) begin
        if (do_store) begin
            vt_mem[slot_q] <= vtag_q;
            pf_mem[slot_q] <= pfn_q;
        end
    end

    assign vtag_out   = vtag_q;
    assign pfn_out    = pfn_q;
    assign slot_out   = slot_q;
    assign miss_flag  = miss_q;
    assign dup_flag   = dup_q;
    assign utlb_flush = flush_q;
endmodule

// File: rtl/sw_tlb_chk.sv
// Port-level protocol checks for sw_tlb, attached by bind.
// Assumes commands are sampled on the rising clock edge.
module sw_tlb_chk
    import sw_tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS) + $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vtag_we,
    input logic             slot_we,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [31:0]      vtag_out,
    input logic [IDX_W-1:0] slot_out,
    input logic             miss_flag,
    input logic             dup_flag,
    input logic             utlb_flush
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    // R9: store raises the flush pulse on the next cycle
    a_r9_store_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STORE) |=> utlb_flush);

    // R9: quiet store never pulses
    a_r9_quiet_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STORE_QUIET) |=> !utlb_flush);

    // R11: a pulse always follows some command
    a_r11_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_flush |-> $past(cmd_valid));

    // R5: miss and duplicate are never reported together
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_flag && dup_flag));

    // R7: allocate lands in the set of the virtual register and clears flags
    a_r7_alloc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ALLOC && !vtag_we && !slot_we) |=>
        (!miss_flag && !dup_flag &&
         slot_out[IDX_W-1:WAY_W] == $past(vtag_out[PAGE_SHIFT +: SET_W])));

    // R4: a miss leaves the slot register untouched
    a_r4_miss_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SEARCH && !slot_we) |=>
        (!miss_flag || $stable(slot_out)));

    // R10: fetch keeps the slot register
    a_r10_fetch_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FETCH && !slot_we) |=> $stable(slot_out));

    // R11: flush-only command leaves the registers alone
    a_r11_flush_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_UFLUSH && !slot_we && !vtag_we) |=>
        ($stable(slot_out) && $stable(vtag_out) && utlb_flush));
endmodule

bind sw_tlb sw_tlb_chk #(.SETS(SETS), .WAYS(WAYS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vtag_we    (vtag_we),
    .slot_we    (slot_we),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .vtag_out   (vtag_out),
    .slot_out   (slot_out),
    .miss_flag  (miss_flag),
    .dup_flag   (dup_flag),
    .utlb_flush (utlb_flush)
);

// File: tb/sw_tlb_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for sw_tlb: a vector table, then directed tests.
module sw_tlb_tb_top;
    localparam logic [2:0] C_SEARCH = 3'd1, C_ALLOC = 3'd2, C_STORE = 3'd3,
                           C_QSTORE = 3'd4, C_FETCH = 3'd5, C_UFLUSH = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic        w0;
        logic [31:0] d0;
        logic        w1;
        logic [31:0] d1;
        logic        wi;
        logic [8:0]  di;
        logic        ck_slot;
        logic [8:0]  e_slot;
        logic        e_miss;
        logic        e_dup;
        logic        e_flush;
        logic        ck_vt;
        logic [31:0] e_vt;
        logic [31:0] e_pf;
        logic [7:0]  rq;
    } vec_t;

    // Virtual descriptor: tag bits above a 7-bit set field at [19:13]
    function automatic logic [31:0] mk(int tag, int set, bit v, bit g, int asid);
        return {12'(tag), 7'(set), 3'b000, v, g, 8'(asid)};
    endfunction

    function automatic vec_t mkv(logic [2:0] op, bit w0, logic [31:0] d0,
                                 bit w1, logic [31:0] d1, bit wi, int di,
                                 bit cks, int es, bit em, bit ed, bit ef,
                                 bit ckv, logic [31:0] ev, logic [31:0] ep, int rq);
        return '{op, w0, d0, w1, d1, wi, 9'(di), cks, 9'(es), em, ed, ef,
                 ckv, ev, ep, 8'(rq)};
    endfunction

    localparam logic [31:0] VA  = mk(1, 5, 1, 0, 3);
    localparam logic [31:0] VB  = mk(2, 5, 1, 0, 3);
    localparam logic [31:0] VA4 = mk(1, 5, 1, 0, 4);
    localparam logic [31:0] VC  = mk(3, 5, 1, 1, 9);
    localparam logic [31:0] VCK = mk(3, 5, 1, 0, 8'h55);
    localparam logic [31:0] VD  = mk(4, 5, 1, 0, 3);
    localparam logic [31:0] VE  = mk(5, 5, 1, 0, 3);
    localparam logic [31:0] VF  = mk(1, 6, 1, 0, 3);
    localparam logic [31:0] P1 = 32'h0004_0A07, P2 = 32'h0008_1B03,
                            P3 = 32'h000C_2C05, P4 = 32'h0010_3D01;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        mkv(C_SEARCH, 1, VA, 0, 0, 0, 0, 1,  0, 1, 0, 0, 0, 0, 0, 4),  // R4 empty set
        mkv(C_ALLOC,  0, 0, 0, 0, 0, 0, 1, 20, 0, 0, 0, 0, 0, 0, 7),    // R7 way 0
        mkv(C_STORE,  0, 0, 1, P1, 0, 0, 1, 20, 0, 0, 1, 0, 0, 0, 9),   // R9 pulse
        mkv(C_SEARCH, 0, 0, 0, 0, 0, 0, 1, 20, 0, 0, 0, 0, 0, 0, 3),    // R3 hit
        mkv(C_ALLOC,  1, VB, 0, 0, 0, 0, 1, 21, 0, 0, 0, 0, 0, 0, 7),   // R7 way 1
        mkv(C_QSTORE, 0, 0, 1, P2, 0, 0, 1, 21, 0, 0, 0, 0, 0, 0, 9),   // R9 quiet
        mkv(C_SEARCH, 0, 0, 0, 0, 0, 0, 1, 21, 0, 0, 0, 0, 0, 0, 3),    // R3 hit
        mkv(C_SEARCH, 1, VA4, 0, 0, 0, 0, 1, 21, 1, 0, 0, 0, 0, 0, 4),  // R4 tag differs
        mkv(C_ALLOC,  1, VC, 0, 0, 0, 0, 1, 22, 0, 0, 0, 0, 0, 0, 7),   // R7 way 2
        mkv(C_STORE,  0, 0, 1, P3, 0, 0, 1, 22, 0, 0, 1, 0, 0, 0, 9),   // R9
        mkv(C_SEARCH, 1, VCK, 0, 0, 0, 0, 1, 22, 0, 0, 0, 0, 0, 0, 6),  // R6 global
        mkv(C_ALLOC,  1, VD, 0, 0, 0, 0, 1, 23, 0, 0, 0, 0, 0, 0, 7),   // R7 way 3
        mkv(C_STORE,  0, 0, 1, P4, 0, 0, 1, 23, 0, 0, 1, 0, 0, 0, 9),   // R9
        mkv(C_ALLOC,  1, VE, 0, 0, 0, 0, 1, 20, 0, 0, 0, 0, 0, 0, 8),   // R8 rr first
        mkv(C_ALLOC,  0, 0, 0, 0, 0, 0, 1, 21, 0, 0, 0, 0, 0, 0, 8),    // R8 rr advances
        mkv(C_FETCH,  0, 0, 0, 0, 1, 21, 1, 21, 0, 0, 0, 1, VB, P2, 10),// R10
        mkv(C_QSTORE, 1, VA, 1, P3, 1, 23, 1, 23, 0, 0, 0, 0, 0, 0, 9), // R9 make dup
        mkv(C_SEARCH, 0, 0, 0, 0, 0, 0, 1, 20, 0, 1, 0, 0, 0, 0, 5),    // R5 dup
        mkv(C_STORE,  1, 0, 1, 0, 1, 20, 1, 20, 0, 1, 1, 0, 0, 0, 12),  // R12 erase
        mkv(C_SEARCH, 1, VA, 0, 0, 0, 0, 1, 23, 0, 0, 0, 0, 0, 0, 12),  // R12 one left
        mkv(C_ALLOC,  1, VE, 0, 0, 0, 0, 1, 20, 0, 0, 0, 0, 0, 0, 7),   // R7 hole first
        mkv(C_FETCH,  0, 0, 0, 0, 0, 0, 1, 20, 0, 0, 0, 1, 0, 0, 12),   // R12 zero back
        mkv(C_UFLUSH, 0, 0, 0, 0, 0, 0, 1, 20, 0, 0, 1, 1, 0, 0, 11),   // R11
        mkv(C_ALLOC,  1, VF, 0, 0, 0, 0, 1, 24, 0, 0, 0, 0, 0, 0, 7),   // R7 set 6
        mkv(C_SEARCH, 0, 0, 0, 0, 0, 0, 1, 24, 1, 0, 0, 0, 0, 0, 4)     // R4 other set
    };

    logic clk = 1'b0;
    logic rst_n;
    logic vtag_we, pfn_we, slot_we, cmd_valid;
    logic [31:0] vtag_wdata, pfn_wdata;
    logic [8:0]  slot_wdata;
    logic [2:0]  cmd_op;
    logic [31:0] vtag_out, pfn_out;
    logic [8:0]  slot_out;
    logic miss_flag, dup_flag, utlb_flush;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    sw_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .vtag_we(vtag_we), .vtag_wdata(vtag_wdata),
        .pfn_we(pfn_we), .pfn_wdata(pfn_wdata),
        .slot_we(slot_we), .slot_wdata(slot_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .vtag_out(vtag_out), .pfn_out(pfn_out), .slot_out(slot_out),
        .miss_flag(miss_flag), .dup_flag(dup_flag), .utlb_flush(utlb_flush)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic idle_inputs();
        vtag_we = 0; pfn_we = 0; slot_we = 0; cmd_valid = 0;
        vtag_wdata = '0; pfn_wdata = '0; slot_wdata = '0; cmd_op = '0;
    endtask

    // One step: write cycle, command cycle, then sample at the falling edge
    task automatic step(vec_t v);
        @(negedge clk);
        vtag_we = v.w0; vtag_wdata = v.d0;
        pfn_we = v.w1;  pfn_wdata = v.d1;
        slot_we = v.wi; slot_wdata = v.di;
        @(negedge clk);
        vtag_we = 0; pfn_we = 0; slot_we = 0;
        cmd_valid = 1; cmd_op = v.op;
        @(negedge clk);
        cmd_valid = 0; cmd_op = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        do_reset();

        // R1: reset state at the ports
        check("R1 slot", 32'(slot_out), 0);
        check("R1 miss", 32'(miss_flag), 0);
        check("R1 dup", 32'(dup_flag), 0);
        check("R1 flush", 32'(utlb_flush), 0);
        check("R1 vtag", vtag_out, 0);
        check("R1 pfn", pfn_out, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            step(VEC[i]);
            tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
            check({tag, " miss"}, 32'(miss_flag), 32'(VEC[i].e_miss));
            check({tag, " dup"}, 32'(dup_flag), 32'(VEC[i].e_dup));
            check({tag, " flush"}, 32'(utlb_flush), 32'(VEC[i].e_flush));
            if (VEC[i].ck_slot) check({tag, " slot"}, 32'(slot_out), 32'(VEC[i].e_slot));
            if (VEC[i].ck_vt) begin
                check({tag, " vtag"}, vtag_out, VEC[i].e_vt);
                check({tag, " pfn"}, pfn_out, VEC[i].e_pf);
            end
        end

        // R9: pulse lasts one cycle only
        @(negedge clk);
        check("R9 pulse width", 32'(utlb_flush), 0);

        // R2: holding register writes without a command
        @(negedge clk);
        vtag_we = 1; vtag_wdata = 32'hA5A5_0312;
        pfn_we = 1;  pfn_wdata = 32'h1234_5678;
        slot_we = 1; slot_wdata = 9'd301;
        @(negedge clk);
        idle_inputs();
        check("R2 vtag", vtag_out, 32'hA5A5_0312);
        check("R2 pfn", pfn_out, 32'h1234_5678);
        check("R2 slot", 32'(slot_out), 301);

        // R1: mid-run reset invalidates stored entries
        do_reset();
        step(mkv(C_SEARCH, 1, VB, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        check("R1 search after reset miss", 32'(miss_flag), 1);
        check("R1 search after reset slot", 32'(slot_out), 0);
        step(mkv(C_ALLOC, 1, VD, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        check("R1 alloc after reset", 32'(slot_out), 20);

        finish_run();
    end
endmodule